// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device end of a three-wire serial nonvolatile memory, as used for small configuration stores. A host selects it with a chip-select, shifts a start bit, an opcode and an address (and, for program commands, a data word) in on a serial data line, one bit per rising edge of a serial clock. The block answers reads on a tri-stateable serial output and performs byte or word program, erase, whole-array erase and whole-array program commands. It also accepts enable and disable commands for programming. Storage is an internal register array. Serial inputs are resynchronised into a fast system clock, and the self-timed program cycle is a counter in that clock domain.

A static organisation input selects 16-bit words or 8-bit bytes over the same storage. While a program cycle runs, the host can poll readiness on the serial output by raising chip-select. The block drives zero while busy and one when ready. A program-enable input adds a hardware lock for the data-carrying program commands.

Top module: `uwire_eeprom`

## Requirements
- R1: A frame begins at the first rising serial-clock edge where chip-select and data-in are both high; rising edges with data-in low before that have no effect.
- R2: After the start bit, two opcode bits select: 10 read, 01 program word, 11 erase word, 00 extended. For 00, the two leading bits of the address field pick: 11 enable programming, 00 disable programming, 10 erase all, 01 program all; the rest of the field is ignored.
- R3: With org16_i high the address field is 10 bits (leading bit ignored, 9-bit word address) and data is 16 bits. With it low the field is 11 bits (leading bit ignored, 10-bit byte address) and data is 8 bits. Byte address b maps to word b>>1, where b[0]=0 is bits [15:8] and b[0]=1 is bits [7:0]. After reset every word reads 16'hFFFF.
- R4: A read drives a 0 following the last address bit, then the addressed word or byte MSB first, with the output changing after each rising serial-clock edge.
- R5: While chip-select stays high, a read continues with the next address without a further zero; the address after the top one is 0.
- R6: After reset programming is disabled. The enable command turns it on and the disable command turns it off. While disabled every program or erase command is dropped, and reads work in either state.
- R7: Erase word sets the addressed location to all ones; erase all sets every word to all ones.
- R8: Program word and program all run only if pe_i is high at the rising edge that carries the last data bit. Program all writes the data to every location.
- R9: An accepted command changes the array only when its cycle ends. busy_o is high for PROG_CYC system cycles (BULK_CYC for erase all and program all). Program or erase commands that complete while busy_o is high are dropped.
- R10: Chip-select low aborts any frame and floats the output; a running program cycle still completes.
- R11: Once a program cycle has been accepted, raising chip-select outside a frame drives 0 on the output while busy and 1 when ready. A new start bit removes this status and floats the output.
- R12: After a frame's last bit, further clock edges and data-in are ignored until chip-select goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, fast relative to the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip-select, active high, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in |
| org16_i | input | 1 | 1 selects 16-bit words, 0 selects bytes; static |
| pe_i | input | 1 | Program enable for program word and program all |
| do_o | output | 1 | Serial data / status out |
| do_oe_o | output | 1 | Output enable for do_o (0 means high impedance) |
| busy_o | output | 1 | High while a program cycle runs |

## Verification
The assertions take for granted that each serial-clock level, and each chip-select level, lasts several system cycles. They also assume data-in is stable around a rising serial edge and that org16_i does not change while chip-select is high or a cycle is pending. The stimulus keeps every serial half period at eight system cycles and changes data-in only while the serial clock is low. It holds chip-select low for many cycles between frames and switches the organisation only when the block is idle with no program cycle pending.

// File: rtl/uwire_pkg.sv
// Shared encodings for the serial EEPROM model: frame states and command codes.
package uwire_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_DATA, ST_READ, ST_DONE
    } uw_state_t;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_ERASE = 2'b11;
    localparam logic [1:0] OPC_EXT   = 2'b00;

    localparam logic [1:0] SUB_EN    = 2'b11;
    localparam logic [1:0] SUB_DIS   = 2'b00;
    localparam logic [1:0] SUB_CLRALL = 2'b10;
    localparam logic [1:0] SUB_SETALL = 2'b01;
endpackage

// File: rtl/uwire_sync.sv
// Two-flop synchroniser bank: brings N asynchronous levels into the clk domain.
// Assumes each input level lasts well over two clk cycles.
module uwire_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] a_i,
    output logic [N-1:0] y_o
);
    logic [N-1:0] meta;

    for (genvar g = 0; g < N; g++) begin : g_bit
        // Two-stage capture of one input bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta[g] <= 1'b0;
                y_o[g]  <= 1'b0;
            end else begin
                meta[g] <= a_i[g];
                y_o[g]  <= meta[g];
            end
        end
    end
endmodule

// File: rtl/uwire_prog_timer.sv
// Self-timed program cycle: a start pulse loads a short or long count.
// busy_o stays high for exactly that many cycles, and done_o marks the last one.
// Assumes LONG_CYC >= SHORT_CYC >= 1; a start while running is ignored.
module uwire_prog_timer #(
    parameter int SHORT_CYC = 500,
    parameter int LONG_CYC  = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic long_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(LONG_CYC + 1);

    logic [CW-1:0] left;
    logic          run;

    // Load on start, count down while running, stop after zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            left <= '0;
        end else if (start_i && !run) begin
            run  <= 1'b1;
            left <= long_i ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
        end else if (run) begin
            if (left == '0) run <= 1'b0;
            else            left <= left - 1'b1;
        end
    end

    assign busy_o = run;
    assign done_o = run && (left == '0);
endmodule

// File: rtl/uwire_eeprom.sv
// Device side of a three-wire serial EEPROM. It recognises a start bit and decodes
// the opcode and address, then runs read (sequential), program, erase and the
// whole-array commands. It keeps the program-enable latch and reports ready/busy
// on the serial output. Assumes org16_i is static while selected or busy, and that
// serial levels are held for several clk cycles.
module uwire_eeprom
    import uwire_pkg::*;
#(
    parameter int WA        = 9,
    parameter int PROG_CYC  = 500,
    parameter int BULK_CYC  = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic di_i,
    input  logic org16_i,
    input  logic pe_i,
    output logic do_o,
    output logic do_oe_o,
    output logic busy_o
);
    localparam int BA    = WA + 1;
    localparam int NWORD = 1 << WA;
    localparam int SHW   = WA + 4;
    localparam int CNTW  = $clog2(WA + 21);

    logic [3:0] sy;
    logic cs_s, sclk_s, di_s, pe_s, sclk_d, rise;
    uw_state_t state_q;
    logic [CNTW-1:0] cnt;
    logic [SHW-2:0] sh;
    logic [14:0] dsh;
    logic [SHW-1:0] hdr_n;
    logic [15:0] dat_n;
    logic [1:0] opc, sub;
    logic [BA-1:0] adr, f_adr, ptr, ptr_inc, pk_adr;
    logic f_all, pk_all, wen_q, stat_pend, go, prog_done;
    logic [15:0] pk_dat, rd_sh, fetch_a, fetch_n;
    logic do_q, rd_first;
    logic [CNTW-1:0] hdr_last, dat_last;
    logic [15:0] mem [NWORD];

    uwire_sync #(.N(4)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .a_i({pe_i, di_i, sclk_i, cs_i}), .y_o(sy)
    );
    assign {pe_s, di_s, sclk_s, cs_s} = sy;

    uwire_prog_timer #(.SHORT_CYC(PROG_CYC), .LONG_CYC(BULK_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(go), .long_i(pk_all),
        .busy_o(busy_o), .done_o(prog_done)
    );

    // Delayed serial clock for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end
    assign rise = sclk_s && !sclk_d;

    // Field positions that depend on the organisation.
    always_comb begin
        hdr_last = org16_i ? CNTW'(WA + 2) : CNTW'(WA + 3);
        dat_last = org16_i ? CNTW'(15) : CNTW'(7);
        hdr_n    = {sh, di_s};
        dat_n    = {dsh, di_s};
        opc      = org16_i ? hdr_n[WA+2:WA+1] : hdr_n[WA+3:WA+2];
        sub      = org16_i ? hdr_n[WA:WA-1]   : hdr_n[WA+1:WA];
        adr      = org16_i ? {1'b0, hdr_n[WA-1:0]} : hdr_n[WA:0];
        ptr_inc  = org16_i ? {1'b0, ptr[WA-1:0] + 1'b1} : ptr + 1'b1;
    end

    // Left-aligned read value for a word or byte pointer.
    function automatic logic [15:0] pick(input logic [15:0] w, input logic lo, input logic o16);
        if (o16) return w;
        return {(lo ? w[7:0] : w[15:8]), 8'h00};
    endfunction

    // Array lookup for the header address and for the next sequential address.
    always_comb begin
        fetch_a = pick(mem[org16_i ? adr[WA-1:0] : adr[WA:1]], adr[0], org16_i);
        fetch_n = pick(mem[org16_i ? ptr_inc[WA-1:0] : ptr_inc[WA:1]], ptr_inc[0], org16_i);
    end

    // Frame state machine: start, header, data, read streaming, and command acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;  cnt <= '0;  sh <= '0;  dsh <= '0;
            f_adr <= '0;  f_all <= 1'b0;  pk_adr <= '0;  pk_all <= 1'b0;
            pk_dat <= '0;  wen_q <= 1'b0;  stat_pend <= 1'b0;  go <= 1'b0;
            ptr <= '0;  rd_sh <= '0;  rd_first <= 1'b0;  do_q <= 1'b0;
        end else begin
            go <= 1'b0;
            if (!cs_s) begin
                state_q <= ST_IDLE;
                cnt     <= '0;
            end else begin
                case (state_q)
                    ST_IDLE: if (rise && di_s) begin
                        state_q   <= ST_CMD;
                        cnt       <= '0;
                        sh        <= '0;
                        stat_pend <= 1'b0;
                    end
                    ST_CMD: if (rise) begin
                        sh  <= hdr_n[SHW-2:0];
                        cnt <= cnt + 1'b1;
                        if (cnt == hdr_last) begin
                            cnt     <= '0;
                            f_adr   <= adr;
                            state_q <= ST_DONE;
                            case (opc)
                                OPC_READ: begin
                                    state_q  <= ST_READ;
                                    ptr      <= adr;
                                    rd_sh    <= fetch_a;
                                    rd_first <= 1'b1;
                                    do_q     <= 1'b0;
                                end
                                OPC_WRITE: begin
                                    state_q <= ST_DATA;
                                    f_all   <= 1'b0;
                                end
                                OPC_ERASE: if (wen_q && !busy_o) begin
                                    go <= 1'b1;  stat_pend <= 1'b1;
                                    pk_all <= 1'b0;  pk_adr <= adr;  pk_dat <= '1;
                                end
                                default: case (sub)
                                    SUB_EN:     wen_q <= 1'b1;
                                    SUB_DIS:    wen_q <= 1'b0;
                                    SUB_CLRALL: if (wen_q && !busy_o) begin
                                        go <= 1'b1;  stat_pend <= 1'b1;
                                        pk_all <= 1'b1;  pk_dat <= '1;
                                    end
                                    default: begin
                                        state_q <= ST_DATA;
                                        f_all   <= 1'b1;
                                    end
                                endcase
                            endcase
                        end
                    end
                    ST_DATA: if (rise) begin
                        dsh <= dat_n[14:0];
                        cnt <= cnt + 1'b1;
                        if (cnt == dat_last) begin
                            state_q <= ST_DONE;
                            if (wen_q && pe_s && !busy_o) begin
                                go <= 1'b1;  stat_pend <= 1'b1;
                                pk_all <= f_all;  pk_adr <= f_adr;  pk_dat <= dat_n;
                            end
                        end
                    end
                    ST_READ: if (rise) begin
                        if (!rd_first && cnt == dat_last + 1'b1) begin
                            ptr   <= ptr_inc;
                            do_q  <= fetch_n[15];
                            rd_sh <= {fetch_n[14:0], 1'b0};
                            cnt   <= CNTW'(1);
                        end else begin
                            do_q  <= rd_sh[15];
                            rd_sh <= {rd_sh[14:0], 1'b0};
                            cnt   <= rd_first ? CNTW'(1) : cnt + 1'b1;
                        end
                        rd_first <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Array update at the end of the self-timed cycle; reset leaves every bit set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORD; i++) mem[i] <= '1;
        end else if (prog_done) begin
            if (pk_all) begin
                for (int i = 0; i < NWORD; i++)
                    mem[i] <= org16_i ? pk_dat : {pk_dat[7:0], pk_dat[7:0]};
            end else if (org16_i) begin
                mem[pk_adr[WA-1:0]] <= pk_dat;
            end else if (pk_adr[0]) begin
                mem[pk_adr[WA:1]][7:0] <= pk_dat[7:0];
            end else begin
                mem[pk_adr[WA:1]][15:8] <= pk_dat[7:0];
            end
        end
    end

    // Output: read data in a read frame, ready/busy status when idle and pending.
    assign do_oe_o = (state_q == ST_READ) || (state_q == ST_IDLE && cs_s && stat_pend);
    assign do_o    = (state_q == ST_READ) ? do_q : !busy_o;
endmodule

// File: rtl/uwire_eeprom_chk.sv
// Protocol checker for uwire_eeprom, attached by bind. Assumes serial levels are
// held for several clk cycles.
module uwire_eeprom_chk
    import uwire_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_s,
    input uw_state_t state_q,
    input logic      do_oe_o,
    input logic      busy_o,
    input logic      wen_q,
    input logic      pk_all,
    input logic [15:0] pk_dat
);
    // R10
    float_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !$past(cs_s)) |-> !do_oe_o);
    // R6
    prog_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(wen_q));
    // R4
    read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |-> do_oe_o);
    // R9
    pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(pk_dat) && $stable(pk_all)));
    // R12
    frame_end_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_DONE || state_q == ST_IDLE));
endmodule

bind uwire_eeprom uwire_eeprom_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .state_q(state_q), .do_oe_o(do_oe_o),
    .busy_o(busy_o), .wen_q(wen_q), .pk_all(pk_all), .pk_dat(pk_dat)
);

// File: tb/uwire_eeprom_test.sv
// Directed bench for uwire_eeprom: one task per scenario, each checking its own results.
module uwire_eeprom_test;
    localparam int WA = 9, PROG = 1000, BULK = 2500, HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0;
    logic org16 = 1'b1, pe = 1'b1;
    logic do_o, do_oe, busy;
    logic s_do, s_oe;
    logic [15:0] rq [4];
    int n_chk = 0, n_bad = 0, cyc = 0, run_len = 0, last_len = 0;

    always #5 clk = ~clk;

    uwire_eeprom #(.WA(WA), .PROG_CYC(PROG), .BULK_CYC(BULK)) uut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .di_i(di),
        .org16_i(org16), .pe_i(pe), .do_o(do_o), .do_oe_o(do_oe), .busy_o(busy)
    );

    // Busy run-length monitor and watchdog.
    always @(negedge clk) begin
        cyc++;
        if (busy) run_len++;
        else if (run_len != 0) begin last_len = run_len; run_len = 0; end
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog (all R) act=%0d exp<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int fw();
        return org16 ? WA + 1 : WA + 2;
    endfunction

    task automatic clk_bit(input logic b);
        @(negedge clk) di = b;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        s_do = do_o; s_oe = do_oe;
        sclk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
    endtask

    task automatic sel();
        @(negedge clk) cs = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic desel();
        @(negedge clk) begin cs = 1'b0; di = 1'b0; end
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic header(input logic [1:0] op, input logic [31:0] fld);
        sel(); clk_bit(1'b1); send({30'b0, op}, 2); send(fld, fw());
    endtask

    task automatic ext(input logic [1:0] sb);
        header(2'b00, 32'(sb) << (fw() - 2));
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        header(2'b01, 32'(a)); send({16'b0, d}, org16 ? 16 : 8); desel();
    endtask

    task automatic wait_ready();
        int t = 0;
        while (busy && t < 5000) begin @(negedge clk); t++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input int a, input int nw);
        header(2'b10, 32'(a));
        chk("R4 dummy zero value", {31'b0, s_do}, 0);
        chk("R4 dummy zero driven", {31'b0, s_oe}, 1);
        for (int w = 0; w < nw; w++) begin
            rq[w] = '0;
            for (int b = 0; b < (org16 ? 16 : 8); b++) begin
                clk_bit(1'b0);
                rq[w] = {rq[w][14:0], s_do};
            end
        end
        desel();
    endtask

    task automatic expect_idle(input string tag);
        logic seen = 1'b0;
        repeat (40) @(negedge clk) if (busy) seen = 1'b1;
        chk(tag, {31'b0, seen}, 0);
    endtask

    task automatic t_reset();
        chk("R10 reset output floats", {31'b0, do_oe}, 0);
        chk("R9 reset not busy", {31'b0, busy}, 0);
        rd(5, 1); chk("R3 reset contents", rq[0], 16'hFFFF);
    endtask

    task automatic t_disabled();
        wr(5, 16'h1234); expect_idle("R6 program dropped while disabled");
        rd(5, 1); chk("R6 array unchanged while disabled", rq[0], 16'hFFFF);
    endtask

    task automatic t_start_and_write();
        sel(); clk_bit(1'b0); clk_bit(1'b0); clk_bit(1'b0); clk_bit(1'b1);
        send(0, 2); send(32'(2'b11) << (fw() - 2), fw()); desel();
        last_len = 0; wr(5, 16'hA5C3); wait_ready();
        chk("R9 word cycle length", last_len, PROG);
        rd(5, 1); chk("R1 frame after low edges", rq[0], 16'hA5C3);
    endtask

    task automatic t_sequential();
        wr(6, 16'h0F0F); wait_ready();
        rd(5, 3);
        chk("R5 seq word0", rq[0], 16'hA5C3);
        chk("R5 seq word1", rq[1], 16'h0F0F);
        chk("R5 seq word2", rq[2], 16'hFFFF);
        wr(511, 16'hBEEF); wait_ready();
        rd(511, 2);
        chk("R5 top word", rq[0], 16'hBEEF);
        chk("R5 rolls to zero", rq[1], 16'hFFFF);
    endtask

    task automatic t_pe_low();
        pe = 1'b0; wr(8, 16'h5555); expect_idle("R8 pe low blocks program");
        pe = 1'b1; rd(8, 1); chk("R8 array unchanged with pe low", rq[0], 16'hFFFF);
    endtask

    task automatic t_status();
        wr(9, 16'h1111);
        sel();
        chk("R11 status driven", {31'b0, do_oe}, 1);
        chk("R11 busy reads 0", {31'b0, do_o}, 0);
        wait_ready();
        chk("R11 ready reads 1", {31'b0, do_o}, 1);
        clk_bit(1'b1);
        chk("R11 start clears status", {31'b0, s_oe}, 0);
        desel();
    endtask

    task automatic t_drop_busy();
        wr(10, 16'h2222); wr(11, 16'h3333); wait_ready();
        rd(10, 1); chk("R9 first command commits", rq[0], 16'h2222);
        rd(11, 1); chk("R9 command during busy dropped", rq[0], 16'hFFFF);
    endtask

    task automatic t_after_frame();
        ext(2'b11);
        clk_bit(1'b1); send(32'b10, 2); send(0, fw()); clk_bit(1'b0);
        chk("R12 edges after frame ignored", {31'b0, s_oe}, 0);
        desel();
    endtask

    task automatic t_abort();
        header(2'b01, 12); send(4'hF, 4); desel();
        chk("R10 output floats after abort", {31'b0, do_oe}, 0);
        expect_idle("R10 aborted frame no cycle");
        rd(12, 1); chk("R10 aborted frame no change", rq[0], 16'hFFFF);
    endtask

    task automatic t_erase_bulk();
        erase_word(5);
        rd(5, 1); chk("R7 erase word", rq[0], 16'hFFFF);
        last_len = 0; ext(2'b10); desel(); wait_ready();
        chk("R9 bulk cycle length", last_len, BULK);
        rd(6, 1); chk("R7 erase all word6", rq[0], 16'hFFFF);
        rd(511, 1); chk("R7 erase all word511", rq[0], 16'hFFFF);
        ext(2'b01); send(16'h7E81, 16); desel(); wait_ready();
        rd(0, 1); chk("R8 program all word0", rq[0], 16'h7E81);
        rd(300, 1); chk("R2 program all word300", rq[0], 16'h7E81);
    endtask

    task automatic erase_word(input int a);
        header(2'b11, 32'(a)); desel(); wait_ready();
    endtask

    task automatic t_disable();
        ext(2'b00); desel();
        header(2'b11, 0); desel(); expect_idle("R6 erase dropped after disable");
        rd(0, 1); chk("R6 read works while disabled", rq[0], 16'h7E81);
    endtask

    task automatic t_bytes();
        org16 = 1'b0;
        ext(2'b11); desel();
        wr(1, 16'h003C); wait_ready();
        rd(0, 3);
        chk("R3 byte0 upper half", rq[0], 16'h007E);
        chk("R3 byte1 lower half", rq[1], 16'h003C);
        chk("R5 byte sequential", rq[2], 16'h007E);
        org16 = 1'b1;
        rd(0, 1); chk("R3 word view of bytes", rq[0], 16'h7E3C);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_disabled();
        t_start_and_write();
        t_sequential();
        t_pe_low();
        t_status();
        t_drop_busy();
        t_after_frame();
        t_abort();
        t_erase_bulk();
        t_disable();
        t_bytes();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule